// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches one serial data bit per clock and raises a single-bit flag in the very cycle in which the bit completing the pattern 1, 1, 0, 1 (oldest first) is presented. The flag is decoded combinationally from the registered history state and the live input bit, so it needs no extra register stage. A consumer samples it on the same clock edge that accepts the final bit.

Matches may share bits. The closing 1 of one match can act as the opening 1 of the next, so a stream such as 1,1,0,1,1,0,1 produces two flags. The history is kept as a four-state encoding: nothing useful seen, a single 1, two or more 1s, or 1,1,0. A synchronous, active-low reset returns it to the empty state.

Top module: `seq1101_detector`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, the history is cleared. From the next cycle on, `hit` is 0 for any `bit_in`, and bits presented before the reset never contribute to a later match.
- R2: `hit` is 1 in a cycle exactly when `bit_in` is 1 and the three bits accepted just before it (since the last reset) were 1, 1, 0, oldest first. Otherwise `hit` is 0. For the stream 0,0,0,1,1,0,1,1,0,0,1,1,0,1, `hit` is 1 only at the 7th and 14th bits.
- R3: Matches overlap. The final 1 of one match counts as the first 1 of the next: for 1,1,0,1,1,0,1, `hit` is 1 at the 4th and 7th bits. `hit` is never 1 in two consecutive cycles, nor in cycles two apart.
- R4: A run of three or more 1s keeps the two-ones history. For 1,1,1,1,0,1, `hit` is 1 only at the 6th bit.
- R5: A 0 following 1,1,0 breaks the partial match. For 1,1,0,0,1, `hit` stays 0, and `hit` is always 0 when `bit_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit, one per cycle |
| hit | output | 1 | Combinational match flag for the current bit |

## Verification
A corrupted history state shows at the port as soon as the next 1 arrives that should or should not complete a match. If a 1,1,0 history is lost, the next 1 misses its flag. If a wrong state claims 1,1,0, a spurious flag appears within one bit. A bad transition out of the two-ones or 1,1,0 states usually only shows two or three bits later, when an overlapping or repeated-1 pattern is presented. The bench therefore drives overlap chains, long runs of 1s, broken patterns, resets in mid-pattern and a long pseudo-random stream.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_TAIL  = 2'd3
    } hist_state_t;

    typedef struct packed {
        hist_state_t st;
    } det_regs_t;

    localparam hist_state_t RESET_STATE = ST_EMPTY;

endpackage

// File: rtl/seq1101_next.sv
module seq1101_next
    import seq1101_pkg::*;
(
    input  hist_state_t cur,
    input  logic        din,
    output hist_state_t nxt
);

    always_comb begin
        nxt = ST_EMPTY;
        unique case (cur)
            ST_EMPTY: nxt = din ? ST_ONE : ST_EMPTY;
            ST_ONE:   nxt = din ? ST_TWO : ST_EMPTY;
            ST_TWO:   nxt = din ? ST_TWO : ST_TAIL;
            ST_TAIL:  nxt = din ? ST_ONE : ST_EMPTY;
            default:  nxt = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/seq1101_out.sv
module seq1101_out
    import seq1101_pkg::*;
(
    input  hist_state_t cur,
    input  logic        din,
    output logic        flag
);

    always_comb begin
        flag = 1'b0;
        if (cur == ST_TAIL) begin
            flag = din;
        end
    end

endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit
);

    det_regs_t   regs_d;
    det_regs_t   regs_q;
    hist_state_t st_next;

    seq1101_next u_next (
        .cur (regs_q.st),
        .din (bit_in),
        .nxt (st_next)
    );

    seq1101_out u_out (
        .cur  (regs_q.st),
        .din  (bit_in),
        .flag (hit)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = st_next;
        if (!rst_n) begin
            regs_d.st = RESET_STATE;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

endmodule

// File: rtl/seq1101_checker.sv
module seq1101_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_in,
    input logic hit
);

    logic [2:0] hist_q;
    logic [1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 3'b000;
            seen_q <= 2'd0;
        end else begin
            hist_q <= {hist_q[1:0], bit_in};
            if (seen_q != 2'd3) begin
                seen_q <= seen_q + 2'd1;
            end
        end
    end

    // R1: the cycle after reset is released, no history survives
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit);

    // R2: flag tracks an independent history of accepted bits
    a_r2_flag_matches_history: assert property (@(posedge clk) disable iff (!rst_n)
        hit == ((seen_q == 2'd3) && (hist_q == 3'b110) && bit_in));

    // R3: no flag in the following cycle
    a_r3_no_adjacent_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R3: no flag two cycles later
    a_r3_gap_of_three: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |=> !hit);

    // R5: a zero bit never completes a match
    a_r5_zero_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |-> !hit);

endmodule

bind seq1101_detector seq1101_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_in),
    .hit    (hit)
);

// File: tb/seq1101_detector_bench.sv
`timescale 1ns/1ps
module seq1101_detector_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic hit;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;

    logic [2:0] m_hist = 3'b000;
    int         m_seen = 0;

    always #2.5 clk = ~clk;

    seq1101_detector u_seq1101_detector (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (bit_in),
        .hit    (hit)
    );

    task automatic push_exp(input logic e, input string req);
        item_t it;
        it.exp = e;
        it.req = req;
        exp_q.push_back(it);
    endtask

    // Model: expected flag comes from the history of bits since reset
    task automatic drive_bit(input logic b, input string req);
        logic e;
        @(negedge clk);
        rst_n  = 1'b1;
        bit_in = b;
        e = (m_seen >= 3) && (m_hist == 3'b110) && b;
        push_exp(e, req);
        m_hist = {m_hist[1:0], b};
        m_seen = m_seen + 1;
    endtask

    task automatic do_reset();
        // first reset cycle: state still unknown, drive 0 so flag is 0
        @(negedge clk);
        rst_n  = 1'b0;
        bit_in = 1'b0;
        push_exp(1'b0, "R1");
        // second reset cycle: history already cleared, a 1 must not flag
        @(negedge clk);
        bit_in = 1'b1;
        push_exp(1'b0, "R1");
        m_hist = 3'b000;
        m_seen = 0;
    endtask

    task automatic drive_seq(input logic [31:0] bits, input int len, input string req);
        for (int i = len - 1; i >= 0; i--) begin
            drive_bit(bits[i], req);
        end
    endtask

    // Monitor: compare one queued expectation per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_vec++;
                if (hit !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: hit=%b expected=%b at %0t", it.req, hit, it.exp, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected=finish", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        // R1 reset state: idle line gives no flag
        drive_seq(32'b0000, 4, "R1");
        // R2 mixed stream: flags at bits 7 and 14
        drive_seq(32'b00011011001101, 14, "R2");
        do_reset();
        // R3 overlapping matches: flags at bits 4 and 7
        drive_seq(32'b1101101, 7, "R3");
        do_reset();
        // R4 long run of ones then 0,1
        drive_seq(32'b111101, 6, "R4");
        drive_seq(32'b11111111101, 11, "R4");
        do_reset();
        // R5 broken tail, then a real match
        drive_seq(32'b11001101, 8, "R5");
        drive_seq(32'b1100, 4, "R5");
        // R1 reset in mid-pattern: 1,1,0 then reset then 1 must not flag
        drive_seq(32'b110, 3, "R1");
        do_reset();
        drive_seq(32'b1, 1, "R1");
        drive_seq(32'b101, 3, "R1");
        // R2 pseudo-random stream
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            drive_bit(lfsr[0], "R2");
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        @(negedge clk);
        rst_n  = 1'b1;
        bit_in = 1'b0;
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule